// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

A first-in first-out buffer, 18 bits wide, that carries words from a write clock domain to a fully independent read clock domain. Neither clock has to be the faster one. Pointers cross between the domains as Gray code through two-flop synchronizers. Full and almost-full are computed against the write clock. Empty and almost-empty are computed against the read clock. Half-full comes from the write side.

The write side is a valid/ready stream: `in_valid` offers a word, and the word is taken on a `wclk` edge unless the buffer is full. A word offered while full is dropped, so the producer must hold off while `in_stat` signals back-pressure. The read side works in one of two timing modes, fixed at master reset. In standard mode, `out_ready` is a read strobe and the word appears one `rclk` edge later. In fall-through mode, the head word is presented on `out_data` unasked with `out_stat` high, and `out_ready` consumes it; that word must stay stable until it is consumed.

A master reset empties the buffer, reloads both flag offsets from one of two presets and samples the timing mode. A partial reset empties the buffer but keeps the offsets and the mode. Offsets can also be loaded from the data bus or bit by bit. A retransmit command rewinds reading to the first stored location.

Top module: `dcfifo18`

## Requirements
- R1: Words leave in the order they were accepted, bit-exact over all 18 bits, across pointer wrap-around.
- R2: In standard mode (`ser_in`=0 during master reset), `out_stat`=1 means empty. An `out_ready` pulse at an `rclk` edge while not empty places the next word on `out_data` after that edge.
- R3: In standard mode, `in_stat`=1 when DEPTH words are stored. An `in_valid` write while full is dropped and stores nothing.
- R4: An `out_ready` pulse while empty is ignored and does not move the read position.
- R5: `half_full`=1 when more than DEPTH/2 words are stored.
- R6: `almost_empty`=1 when the stored level is at or below the almost-empty offset. In fall-through mode the level counts the presented word.
- R7: `almost_full`=1 when the stored count is at least DEPTH minus the almost-full offset.
- R8: Master reset (`mrst`, held for some edges of both clocks) empties the buffer and sets both offsets to 7 if `preset_sel`=0, or to 63 if `preset_sel`=1. It takes the timing mode from `ser_in`, where 1 selects fall-through.
- R9: Partial reset (`prst`) empties the buffer and keeps the offsets and the timing mode.
- R10: While `cfg_load`=1, each `in_valid` cycle loads `in_data[6:0]` into the offsets, in the order almost-empty first, then almost-full, alternating. Nothing is written to the buffer.
- R11: While `cfg_load`=1 and `ser_en`=1, each `wclk` edge takes one bit from `ser_in`. The first 7 bits fill the almost-empty offset, LSB first. The next 7 bits fill the almost-full offset, LSB first.
- R12: In fall-through mode, `out_stat`=1 means a valid word is on `out_data` with no request. `out_ready` consumes it, and `in_stat`=1 means space is available.
- R13: A `rtx` pulse rewinds reading to location 0, so words are replayed from the first one written since reset.
- R14: `out_drive` follows `oe`. When `oe`=0, `out_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous in each domain |
| prst | input | 1 | Partial reset, keeps offsets and mode |
| preset_sel | input | 1 | Selects offset preset at master reset |
| in_valid | input | 1 | Write request / offset load strobe |
| in_data | input | 18 | Write data |
| cfg_load | input | 1 | Routes writes to the offset registers |
| ser_en | input | 1 | Serial offset bit enable |
| ser_in | input | 1 | Mode select during reset, serial bit after |
| in_stat | output | 1 | Full (standard) or input-ready (fall-through) |
| out_ready | input | 1 | Read strobe or consume |
| rtx | input | 1 | Retransmit |
| oe | input | 1 | Output enable |
| out_data | output | 18 | Read data |
| out_drive | output | 1 | Tri-state drive enable |
| out_stat | output | 1 | Empty (standard) or output-ready (fall-through) |
| half_full | output | 1 | More than half stored |
| almost_empty | output | 1 | Level at or below offset |
| almost_full | output | 1 | Free space at or below offset |

## Verification
The bench walks the fill level through each flag threshold in both directions, including exactly full and exactly empty. An off-by-one in the compare would move a flag one word early or late. A write attempted at full and a read attempted at empty are followed by reads that expose corrupted order or a read pointer that slipped. Offsets are loaded in parallel and serially and then observed through the flag thresholds. A swapped load order or bit order would move the almost-empty or almost-full edge. A partial reset must keep these offsets and a master reset must restore the presets. Retransmit must replay from the first word. Fall-through mode must present its first word unasked and hold it until it is consumed.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W    = 18;
  localparam int PRESET_LO = 7;
  localparam int PRESET_HI = 63;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  always_comb begin
    bin_out[W-1] = stage2[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ stage2[i];
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 18,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr.sv
module dcf_wr #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          preset_sel,
  input  logic          in_valid,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_word,
  input  logic          ser_en,
  input  logic          ser_in,
  input  logic [PW-1:0] rbin_s,
  output logic          push,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          afull,
  output logic          half,
  output logic [AW-1:0] ae_off,
  output logic          fwft
);
  localparam int SW = $clog2(2 * AW);
  localparam logic [AW-1:0] PRE_LO = AW'(dcf_pkg::PRESET_LO);
  localparam logic [AW-1:0] PRE_HI = AW'(dcf_pkg::PRESET_HI);

  logic [AW-1:0] af_off;
  logic [PW-1:0] wcount, wbin_nx;
  logic          psel;
  logic [SW-1:0] sidx;

  assign wcount  = wbin - rbin_s;
  assign full    = (wcount == PW'(DEPTH));
  assign afull   = (wcount >= PW'(DEPTH) - {1'b0, af_off});
  assign half    = (wcount > PW'(DEPTH / 2));
  assign push    = in_valid && !cfg_load && !full;
  assign wbin_nx = wbin + PW'(1);

  always_ff @(posedge wclk) begin
    if (mrst) begin
      wbin   <= '0;
      wgray  <= '0;
      fwft   <= ser_in;
      ae_off <= preset_sel ? PRE_HI : PRE_LO;
      af_off <= preset_sel ? PRE_HI : PRE_LO;
      psel   <= 1'b0;
      sidx   <= '0;
    end else if (prst) begin
      wbin  <= '0;
      wgray <= '0;
      psel  <= 1'b0;
      sidx  <= '0;
    end else begin
      if (push) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (cfg_load && in_valid) begin
        if (!psel) ae_off <= cfg_word;
        else       af_off <= cfg_word;
        psel <= ~psel;
      end
      if (cfg_load && ser_en) begin
        for (int b = 0; b < AW; b++) begin
          if (sidx == SW'(b))      ae_off[b] <= ser_in;
          if (sidx == SW'(b + AW)) af_off[b] <= ser_in;
        end
        sidx <= (sidx == SW'(2 * AW - 1)) ? '0 : sidx + SW'(1);
      end
    end
  end

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (mrst || prst)
    wcount <= PW'(DEPTH));
  p_full_flags_r5: assert property (@(posedge wclk) disable iff (mrst || prst)
    full |-> (half && afull));
  p_gray_step_r1: assert property (@(posedge wclk) disable iff (mrst || prst)
    !$past(mrst || prst) |-> ($countones(wgray ^ $past(wgray)) <= 1));
  p_preset_r8: assert property (@(posedge wclk) disable iff (mrst || prst)
    $past(mrst) |-> (ae_off == ($past(preset_sel) ? PRE_HI : PRE_LO)));
  p_load_no_push_r10: assert property (@(posedge wclk) disable iff (mrst || prst)
    cfg_load |=> $stable(wbin));
endmodule

// File: rtl/dcf_rd.sv
module dcf_rd #(
  parameter int DEPTH = 128,
  parameter int DW    = 18,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          ser_in,
  input  logic          out_ready,
  input  logic          rtx,
  input  logic [PW-1:0] wbin_s,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] ae_off,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] dout,
  output logic          oreg_valid,
  output logic          mem_empty,
  output logic          aempty,
  output logic          fwft
);
  logic [PW-1:0] count_r, level, rbin_nx;
  logic          pop;

  assign count_r   = wbin_s - rbin;
  assign mem_empty = (count_r == '0);
  assign level     = count_r + PW'(fwft && oreg_valid);
  assign aempty    = (level <= {1'b0, ae_off});
  assign rbin_nx   = rbin + PW'(1);
  assign pop       = !mem_empty && (fwft ? (!oreg_valid || out_ready) : out_ready);

  always_ff @(posedge rclk) begin
    if (mrst || prst) begin
      rbin       <= '0;
      rgray      <= '0;
      oreg_valid <= 1'b0;
      dout       <= '0;
      if (mrst) fwft <= ser_in;
    end else if (rtx) begin
      rbin       <= '0;
      rgray      <= '0;
      oreg_valid <= 1'b0;
    end else begin
      if (pop) begin
        dout  <= mem_rdata;
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
      if (fwft) begin
        if (pop)            oreg_valid <= 1'b1;
        else if (out_ready) oreg_valid <= 1'b0;
      end
    end
  end

  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (mrst || prst)
    (!fwft && mem_empty && out_ready && !rtx) |=> $stable(rbin));
  p_level_bound_r3: assert property (@(posedge rclk) disable iff (mrst || prst)
    count_r <= PW'(DEPTH));
  p_fwft_hold_r12: assert property (@(posedge rclk) disable iff (mrst || prst)
    (fwft && oreg_valid && !out_ready && !rtx) |=> (oreg_valid && $stable(dout)));
  p_std_no_oreg_r2: assert property (@(posedge rclk) disable iff (mrst || prst)
    !fwft |-> !oreg_valid);
endmodule

// File: rtl/dcfifo18.sv
module dcfifo18 #(
  parameter int DEPTH = 128,
  parameter int DW    = dcf_pkg::DATA_W,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          preset_sel,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          cfg_load,
  input  logic          ser_en,
  input  logic          ser_in,
  output logic          in_stat,
  input  logic          out_ready,
  input  logic          rtx,
  input  logic          oe,
  output logic [DW-1:0] out_data,
  output logic          out_drive,
  output logic          out_stat,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  logic [PW-1:0] wbin, wgray, rbin, rgray, wbin_s, rbin_s;
  logic [AW-1:0] ae_off;
  logic [DW-1:0] mem_rdata, dout;
  logic          push, full, fwft_w, fwft_r, oreg_valid, mem_empty;

  dcf_wr #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .mrst(mrst), .prst(prst), .preset_sel(preset_sel),
    .in_valid(in_valid), .cfg_load(cfg_load), .cfg_word(in_data[AW-1:0]),
    .ser_en(ser_en), .ser_in(ser_in), .rbin_s(rbin_s), .push(push),
    .wbin(wbin), .wgray(wgray), .full(full), .afull(almost_full),
    .half(half_full), .ae_off(ae_off), .fwft(fwft_w)
  );

  dcf_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst(mrst || prst), .gray_in(wgray), .bin_out(wbin_s)
  );

  dcf_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst(mrst || prst), .gray_in(rgray), .bin_out(rbin_s)
  );

  dcf_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .wclk(wclk), .we(push), .waddr(wbin[AW-1:0]), .wdata(in_data),
    .raddr(rbin[AW-1:0]), .rdata(mem_rdata)
  );

  dcf_rd #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .rclk(rclk), .mrst(mrst), .prst(prst), .ser_in(ser_in),
    .out_ready(out_ready), .rtx(rtx), .wbin_s(wbin_s), .mem_rdata(mem_rdata),
    .ae_off(ae_off), .rbin(rbin), .rgray(rgray), .dout(dout),
    .oreg_valid(oreg_valid), .mem_empty(mem_empty), .aempty(almost_empty),
    .fwft(fwft_r)
  );

  assign in_stat   = fwft_w ? !full : full;
  assign out_stat  = fwft_r ? oreg_valid : mem_empty;
  assign out_drive = oe;
  assign out_data  = oe ? dout : '0;
endmodule

// File: tb/test_dcfifo18.sv
module test_dcfifo18;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int NVEC = 14;
  // {level[7:0], flags {out_stat, almost_empty, half_full, almost_full, in_stat}}
  localparam logic [12:0] VEC [NVEC] = '{
    {8'd0,   5'b11000}, {8'd1,   5'b01000}, {8'd7,   5'b01000},
    {8'd8,   5'b00000}, {8'd64,  5'b00000}, {8'd65,  5'b00100},
    {8'd121, 5'b00110}, {8'd128, 5'b00111}, {8'd127, 5'b00110},
    {8'd65,  5'b00100}, {8'd64,  5'b00000}, {8'd8,   5'b00000},
    {8'd7,   5'b01000}, {8'd0,   5'b11000}
  };

  logic wclk = 0, rclk = 0;
  logic mrst = 1, prst = 0, preset_sel = 0, in_valid = 0, cfg_load = 0;
  logic ser_en = 0, ser_in = 0, out_ready = 0, rtx = 0, oe = 1;
  logic [17:0] in_data = '0;
  logic [17:0] out_data;
  logic in_stat, out_drive, out_stat, half_full, almost_empty, almost_full;
  int total = 0, bad = 0, cur = 0;
  logic [17:0] wcnt = '0, rcnt = '0;

  always #(CLK_PERIOD / 2) wclk = ~wclk;
  always #(RCLK_PERIOD / 2) rclk = ~rclk;

  dcfifo18 i_dcfifo18 (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .preset_sel(preset_sel),
    .in_valid(in_valid), .in_data(in_data), .cfg_load(cfg_load), .ser_en(ser_en),
    .ser_in(ser_in), .in_stat(in_stat), .out_ready(out_ready), .rtx(rtx), .oe(oe),
    .out_data(out_data), .out_drive(out_drive), .out_stat(out_stat),
    .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  function automatic logic [4:0] flags();
    return {out_stat, almost_empty, half_full, almost_full, in_stat};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [17:0] v);
    @(negedge wclk); in_valid = 1; in_data = v;
    @(posedge wclk); #1 in_valid = 0;
  endtask

  task automatic pop_chk(string tag, logic [17:0] exp);
    @(negedge rclk); out_ready = 1;
    @(posedge rclk); #1 out_ready = 0;
    @(negedge rclk); chk(tag, 32'(out_data), 32'(exp));
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    @(negedge rclk);
  endtask

  task automatic do_mrst(logic sel, logic mode);
    @(negedge wclk); mrst = 1; preset_sel = sel; ser_in = mode;
    repeat (4) @(posedge rclk);
    repeat (2) @(posedge wclk);
    @(negedge wclk); mrst = 0; ser_in = 0;
    wcnt = '0; rcnt = '0; cur = 0;
    settle();
  endtask

  task automatic do_prst();
    @(negedge wclk); prst = 1;
    repeat (4) @(posedge rclk);
    repeat (2) @(posedge wclk);
    @(negedge wclk); prst = 0;
    rcnt = wcnt; cur = 0;
    settle();
  endtask

  task automatic fill(int n);
    for (int k = 0; k < n; k++) begin push(wcnt); wcnt++; cur++; end
  endtask

  task automatic drain();
    while (cur > 0) begin pop_chk("R1 drain order", rcnt); rcnt++; cur--; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_mrst(1'b0, 1'b0);
    chk("R8 reset flags", 32'(flags()), 32'(5'b11000));
    chk("R14 drive on", 32'(out_drive), 32'd1);

    // table walk: standard mode, offsets preset 7
    for (int i = 0; i < NVEC; i++) begin
      int tgt;
      tgt = int'(VEC[i][12:5]);
      while (cur < tgt) begin push(wcnt); wcnt++; cur++; end
      while (cur > tgt) begin pop_chk("R1 R2 order", rcnt); rcnt++; cur--; end
      settle();
      chk("R2 R3 R5 R6 R7 flag vector", 32'(flags()), 32'(VEC[i][4:0]));
      if (tgt == 128) begin
        push(18'h3FFFF);
        settle();
        chk("R3 write while full", 32'(flags()), 32'(VEC[i][4:0]));
      end
    end

    // R4: read at empty is ignored
    @(negedge rclk); out_ready = 1;
    @(posedge rclk); #1 out_ready = 0;
    fill(1);
    settle();
    chk("R4 level after empty read", 32'(flags()), 32'(5'b01000));
    pop_chk("R4 data after empty read", rcnt); rcnt++; cur--;

    // R10: parallel load ae=3, af=5, no buffer write; then R9 partial reset
    settle();
    @(negedge wclk); cfg_load = 1; in_valid = 1; in_data = 18'd3;
    @(negedge wclk); in_data = 18'd5;
    @(negedge wclk); in_valid = 0; cfg_load = 0;
    settle();
    chk("R10 load writes nothing", 32'(out_stat), 32'd1);
    fill(3); settle();
    chk("R10 ae at 3", 32'(almost_empty), 32'd1);
    fill(1); settle();
    chk("R10 ae clear at 4", 32'(almost_empty), 32'd0);
    do_prst();
    chk("R9 empty after prst", 32'(flags()), 32'(5'b11000));
    fill(4); settle();
    chk("R9 offset kept", 32'(almost_empty), 32'd0);
    drain();

    // R11: serial load ae=10, af=20
    do_prst();
    begin
      logic [13:0] sv;
      sv = {7'd20, 7'd10};
      for (int b = 0; b < 14; b++) begin
        @(negedge wclk); cfg_load = 1; ser_en = 1; ser_in = sv[b];
      end
      @(negedge wclk); cfg_load = 0; ser_en = 0; ser_in = 0;
    end
    settle();
    fill(10); settle();
    chk("R11 ae at 10", 32'(almost_empty), 32'd1);
    fill(1); settle();
    chk("R11 ae clear at 11", 32'(almost_empty), 32'd0);
    fill(96); settle();
    chk("R11 af clear at 107", 32'(almost_full), 32'd0);
    fill(1); settle();
    chk("R11 af at 108", 32'(almost_full), 32'd1);
    drain();

    // R8: master reset with high preset (63)
    do_mrst(1'b1, 1'b0);
    fill(63); settle();
    chk("R8 ae at 63", 32'(almost_empty), 32'd1);
    fill(1); settle();
    chk("R8 R5 R7 flags at 64", 32'(flags()), 32'(5'b00000));
    fill(1); settle();
    chk("R8 R5 R7 flags at 65", 32'(flags()), 32'(5'b00110));
    drain();

    // R13: retransmit
    do_mrst(1'b0, 1'b0);
    fill(5);
    settle();
    pop_chk("R13 pre", 18'd0); pop_chk("R13 pre", 18'd1); pop_chk("R13 pre", 18'd2);
    @(negedge rclk); rtx = 1;
    @(posedge rclk); #1 rtx = 0;
    settle();
    chk("R13 level after rtx", 32'(flags()), 32'(5'b01000));
    for (int k = 0; k < 5; k++) pop_chk("R13 replay", 18'(k));
    settle();
    chk("R13 empty after replay", 32'(out_stat), 32'd1);

    // R12: fall-through mode
    do_mrst(1'b0, 1'b1);
    chk("R12 idle stats", 32'({out_stat, in_stat}), 32'(2'b01));
    push(18'd200); push(18'd201);
    settle();
    chk("R12 first word unasked", 32'(out_data), 32'd200);
    chk("R12 output ready", 32'(out_stat), 32'd1);
    @(negedge rclk); oe = 0;
    #1 chk("R14 data off", 32'(out_data), 32'd0);
    chk("R14 drive off", 32'(out_drive), 32'd0);
    @(negedge rclk); oe = 1;
    pop_chk("R12 second word", 18'd201);
    chk("R12 still ready", 32'(out_stat), 32'd1);
    @(negedge rclk); out_ready = 1;
    @(posedge rclk); #1 out_ready = 0;
    settle();
    chk("R12 drained", 32'(out_stat), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule